// File: doc/BRIEF.md
# Strap-Addressed I2C Configuration Register Target

This block is an I2C target that exposes a bank of 8-bit configuration and status registers to a bus controller. Its 7-bit bus address is not programmed: it is set by two board straps, each of which has four levels and reaches the block already decoded to a 2-bit code. SCL and SDA are brought into the system clock domain through a short synchronizer. The block finds START and STOP conditions, matches the address, acknowledges, and then either takes a one-byte register pointer followed by data bytes or sends register bytes back. SDA is driven through an open-drain enable.

One register pointer serves both directions and advances by one for every byte moved. A write that carries only the pointer byte sets where the next read begins. A read with no pointer write before it carries on after the last byte read, and after reset it begins at register 0x00. Registers are plain read/write, write-1-to-set, write-1-to-clear with hardware-set flags, or read-only status loaded by hardware. All registers are visible in parallel on an output bus.

The control and data pins of this block are plain level signals. The I2C bus has no valid/ready pair at this edge, so there is no back-pressure path. The controller paces every transfer with SCL, and the block never stretches the clock.

Top module: `i2c_strap_regs`

## Requirements
- R1: The bus address is a base set by the high strap OR'd with the low strap code (level code 00, 01, 10, 11 for the four strap levels, given to the low address bits as-is). The high strap code selects the base: 00 gives 0x44, 01 gives 0x40, 10 gives 0x20, 11 gives 0x0C.
- R2: An address byte (7 address bits MSB first, then the R/W bit, 1 = read) that matches is acknowledged by pulling SDA low. A byte that does not match gets no acknowledge, and the block stays silent on every later byte until the next START.
- R3: In a write, the byte after the address is the register pointer. Every following byte is stored at the pointer, which then advances by one. Each byte is acknowledged.
- R4: A write made of the address and the pointer byte only, closed by STOP, changes no register and makes the next read start at that pointer.
- R5: A read sends the register at the pointer MSB first and advances the pointer. While the controller acknowledges, the next register follows.
- R6: The first read after reset starts at register 0x00. Later reads with no pointer write between them continue at the last register read plus one.
- R7: After the controller does not acknowledge a read byte, SDA stays released through any further SCL pulses until STOP or a repeated START. A repeated START begins address matching again and keeps the pointer.
- R8: On reset, register 0x0A holds 0x01 and every other register holds 0x00.
- R9: Register 0x08 is write-1-to-set: a written 1 sets the bit and a written 0 leaves it unchanged.
- R10: Register 0x09 holds flags. A pulse on a hardware flag input sets that bit. A written 1 clears the bit and a written 0 leaves it unchanged. When hardware sets a bit in the same cycle that software clears it, the bit is set.
- R11: Register 0x0B ignores bus writes and loads the hardware status value in any cycle where the status load strobe is high.
- R12: Registers at addresses 0x10 and above read as 0x00. Bus writes to them are acknowledged but change nothing.
- R13: SDA is released on STOP, and the block starts driving SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain drive) |
| strap_lo_i | input | 2 | Decoded level code of the strap for the low address bits |
| strap_hi_i | input | 2 | Decoded level code of the strap that selects the address base |
| hw_flag_set_i | input | 8 | One-cycle pulses that set the flag bits in register 0x09 |
| hw_stat_we_i | input | 1 | Load strobe for the status register 0x0B |
| hw_stat_i | input | 8 | Value loaded into register 0x0B |
| regs_o | output | NREG*8 | All registers in parallel, register n at bits [8n+7:8n] |

## Verification
A pin edge reaches the bus engine three clock cycles later: two synchronizer stages, then the edge detector. So SDA drive for an acknowledge or a read bit changes three cycles after the SCL falling edge. A bus write reaches its register one cycle after that, and a hardware pulse shows in regs_o at the next clock edge. The bench drives the bus with a quarter-bit of eight clocks. It samples SDA in the middle of SCL high, checks registers a quarter-bit or more after the last bus edge, and checks hardware-loaded registers at the falling clock edge after the pulse, so every check comes after its result is due.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_WDATA,
    ST_ACK_W,
    ST_RDATA,
    ST_RACK,
    ST_HOLD
  } tgt_state_e;

  localparam int unsigned SET_IDX  = 8;
  localparam int unsigned FLAG_IDX = 9;
  localparam int unsigned CTRL_IDX = 10;
  localparam int unsigned STAT_IDX = 11;

  function automatic logic [7:0] reg_reset(int unsigned idx);
    return (idx == CTRL_IDX) ? 8'h01 : 8'h00;
  endfunction

  // plain read/write bits
  function automatic logic [7:0] reg_wmask(int unsigned idx);
    return (idx < SET_IDX || idx == CTRL_IDX || idx > STAT_IDX) ? 8'hFF : 8'h00;
  endfunction

  // write-one-to-set bits
  function automatic logic [7:0] reg_smask(int unsigned idx);
    return (idx == SET_IDX) ? 8'hFF : 8'h00;
  endfunction

  // write-one-to-clear bits
  function automatic logic [7:0] reg_cmask(int unsigned idx);
    return (idx == FLAG_IDX) ? 8'hFF : 8'h00;
  endfunction

endpackage

// File: rtl/strap_addr_dec.sv
module strap_addr_dec (
  input  logic [1:0] lvl_lo_i,
  input  logic [1:0] lvl_hi_i,
  output logic [6:0] addr_o
);
  logic [6:0] base;

  always_comb begin
    case (lvl_hi_i)
      2'b00:   base = 7'h44;
      2'b01:   base = 7'h40;
      2'b10:   base = 7'h20;
      default: base = 7'h0C;
    endcase
    addr_o = base | {5'd0, lvl_lo_i};
  end
endmodule

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_strap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       sda_i,
  input  logic [6:0] own_addr_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] ptr_o,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  tgt_state_e state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic [7:0] ptr;
  logic       rw;
  logic       ack_seen;
  logic [2:0] tx_idx;

  assign tx_idx = 3'(4'd7 - cnt);
  assign ptr_o  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      ack_seen  <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_i};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall_i && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == own_addr_i) begin
                  rw       <= shreg[0];
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                ptr      <= shreg;
                sda_oe_o <= 1'b1;
                state    <= ST_ACK_SUB;
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= shreg;
                ptr       <= ptr + 8'd1;
                sda_oe_o  <= 1'b1;
                state     <= ST_ACK_W;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall_i) begin
              cnt <= '0;
              if (rw) begin
                tx       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr      <= ptr + 8'd1;
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_SUB;
              end
            end
          end
          ST_ACK_SUB, ST_ACK_W: begin
            if (scl_fall_i) begin
              cnt      <= '0;
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt <= cnt + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx[tx_idx];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              ack_seen <= ~sda_i;
            end else if (scl_fall_i) begin
              if (ack_seen) begin
                tx       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                ptr      <= ptr + 8'd1;
                cnt      <= '0;
                state    <= ST_RDATA;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_strap_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [7:0]      wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [7:0]      rd_addr_i,
  input  logic [7:0]      hw_flag_set_i,
  input  logic            hw_stat_we_i,
  input  logic [7:0]      hw_stat_i,
  output logic [7:0]      rd_data_o,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] RST = reg_reset(i);
    localparam logic [7:0] WM  = reg_wmask(i);
    localparam logic [7:0] SM  = reg_smask(i);
    localparam logic [7:0] CM  = reg_cmask(i);
    logic [7:0] q;
    logic [7:0] nxt;
    logic       sel;

    assign sel = wr_en_i && (wr_addr_i == 8'(i));

    always_comb begin
      nxt = q;
      if (sel) begin
        nxt = (nxt & ~WM) | (wr_data_i & WM);
        nxt = nxt | (wr_data_i & SM);
        nxt = nxt & ~(wr_data_i & CM);
      end
      if (i == FLAG_IDX) nxt = nxt | hw_flag_set_i;
      if (i == STAT_IDX && hw_stat_we_i) nxt = hw_stat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= nxt;
    end

    assign regs_o[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == 8'(i)) rd_data_o = regs_o[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2c_strap_regs.sv
module i2c_strap_regs #(
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        strap_lo_i,
  input  logic [1:0]        strap_hi_i,
  input  logic [7:0]        hw_flag_set_i,
  input  logic              hw_stat_we_i,
  input  logic [7:0]        hw_stat_i,
  output logic [NREG*8-1:0] regs_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] own_addr;
  logic [7:0] ptr, rd_data, wr_addr, wr_data;
  logic       wr_en;

  strap_addr_dec u_addr (
    .lvl_lo_i (strap_lo_i),
    .lvl_hi_i (strap_hi_i),
    .addr_o   (own_addr)
  );

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_i      (sda_s),
    .own_addr_i (own_addr),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  cfg_reg_bank #(.NREG(NREG)) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .rd_addr_i     (ptr),
    .hw_flag_set_i (hw_flag_set_i),
    .hw_stat_we_i  (hw_stat_we_i),
    .hw_stat_i     (hw_stat_i),
    .rd_data_o     (rd_data),
    .regs_o        (regs_o)
  );
endmodule

// File: rtl/i2c_strap_regs_chk.sv
module i2c_strap_regs_chk
  import i2c_strap_pkg::*;
#(
  parameter int NREG = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              stop_det,
  input logic [NREG*8-1:0] regs,
  input logic [7:0]        hw_set,
  input logic              hw_we
);
  logic [7:0] set_r, flag_r, stat_r, ctrl_r, reg0_r;
  assign set_r  = regs[SET_IDX*8 +: 8];
  assign flag_r = regs[FLAG_IDX*8 +: 8];
  assign stat_r = regs[STAT_IDX*8 +: 8];
  assign ctrl_r = regs[CTRL_IDX*8 +: 8];
  assign reg0_r = regs[7:0];

  a_r13_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r13_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r8_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_r == 8'h01 && reg0_r == 8'h00 && flag_r == 8'h00));

  a_r9_set_bits_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((set_r & $past(set_r)) == $past(set_r)));

  a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != 8'h00) |=> ((flag_r & $past(hw_set)) == $past(hw_set)));

  a_r11_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_we |=> $stable(stat_r));
endmodule

bind i2c_strap_regs i2c_strap_regs_chk #(.NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe_o),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .regs     (regs_o),
  .hw_set   (hw_flag_set_i),
  .hw_we    (hw_stat_we_i)
);

// File: tb/i2c_strap_regs_test.sv
module i2c_strap_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREG       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [1:0] strap_lo = 2'b00;
  logic [1:0] strap_hi = 2'b00;
  logic [7:0] hw_set = 8'h00;
  logic hw_we = 1'b0;
  logic [7:0] hw_stat = 8'h00;
  logic [NREG*8-1:0] regs;
  logic [6:0] own;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_strap_regs #(.NREG(NREG)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl),
    .sda_i         (sda_line),
    .sda_oe_o      (sda_oe),
    .strap_lo_i    (strap_lo),
    .strap_hi_i    (strap_hi),
    .hw_flag_set_i (hw_set),
    .hw_stat_we_i  (hw_we),
    .hw_stat_i     (hw_stat),
    .regs_o        (regs)
  );

  function automatic logic [6:0] exp_addr(logic [1:0] hi, logic [1:0] lo);
    logic [6:0] b;
    case (hi)
      2'b00: b = 7'h44;
      2'b01: b = 7'h40;
      2'b10: b = 7'h20;
      default: b = 7'h0C;
    endcase
    return b | {5'd0, lo};
  endfunction

  function automatic logic [7:0] rb(int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  // single-register write with acknowledge checks
  task automatic write_reg(string req, logic [7:0] sub, logic [7:0] val);
    logic a;
    bus_start();
    put_byte({own, 1'b0}, a); check(req, {7'd0, a}, 8'h01);
    put_byte(sub, a);         check(req, {7'd0, a}, 8'h01);
    put_byte(val, a);         check(req, {7'd0, a}, 8'h01);
    bus_stop();
  endtask

  task automatic read_one(string req, logic [7:0] sub, logic [7:0] exp);
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte({own, 1'b0}, a);
    put_byte(sub, a);
    bus_stop();
    bus_start();
    put_byte({own, 1'b1}, a); check(req, {7'd0, a}, 8'h01);
    get_byte(v, 1'b0);        check(req, v, exp);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R8 sda idle", {7'd0, sda_oe}, 8'h00);
    for (int i = 0; i < NREG; i++) check("R8 reset value", rb(i), (i == 10) ? 8'h01 : 8'h00);
  endtask

  task automatic t_first_read();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte({own, 1'b1}, a); check("R2 read addr ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 11; i++) begin
      get_byte(v, i != 10);
      check("R6 first read from 0x00", v, (i == 10) ? 8'h01 : 8'h00);
    end
    bus_stop();
    check("R13 released after stop", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_straps();
    logic a;
    logic [6:0] ea;
    for (int h = 0; h < 4; h++) begin
      for (int l = 0; l < 4; l++) begin
        strap_hi = 2'(h);
        strap_lo = 2'(l);
        ea = exp_addr(2'(h), 2'(l));
        tick(Q);
        bus_start();
        put_byte({ea, 1'b0}, a); check("R1 strap address ack", {7'd0, a}, 8'h01);
        bus_stop();
        bus_start();
        put_byte({ea ^ 7'h01, 1'b0}, a); check("R2 other address nack", {7'd0, a}, 8'h00);
        put_byte(8'h00, a);              check("R2 silent until start", {7'd0, a}, 8'h00);
        bus_stop();
      end
    end
    strap_hi = 2'b10;
    strap_lo = 2'b01;
    own = exp_addr(2'b10, 2'b01);
    tick(Q);
  endtask

  task automatic t_write_burst();
    logic a;
    logic [7:0] d [4];
    d[0] = 8'h5A; d[1] = 8'hA5; d[2] = 8'h3C; d[3] = 8'hC3;
    bus_start();
    put_byte({own, 1'b0}, a); check("R3 addr ack", {7'd0, a}, 8'h01);
    put_byte(8'h02, a);       check("R3 pointer ack", {7'd0, a}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      put_byte(d[i], a); check("R3 data ack", {7'd0, a}, 8'h01);
    end
    bus_stop();
    for (int i = 0; i < 4; i++) check("R3 burst stored", rb(2 + i), d[i]);
  endtask

  task automatic t_pointer_read();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte({own, 1'b0}, a);
    put_byte(8'h03, a);
    bus_stop();
    check("R4 pointer write changes nothing", rb(3), 8'hA5);
    bus_start();
    put_byte({own, 1'b1}, a);
    get_byte(v, 1'b1); check("R4 read at pointer", v, 8'hA5);
    get_byte(v, 1'b0); check("R5 next on ack", v, 8'h3C);
    bus_stop();
    bus_start();
    put_byte({own, 1'b1}, a);
    get_byte(v, 1'b0); check("R6 resume after last read", v, 8'hC3);
    bus_stop();
  endtask

  task automatic t_set_bits();
    write_reg("R9 write", 8'h08, 8'h0F); check("R9 set low", rb(8), 8'h0F);
    write_reg("R9 write", 8'h08, 8'hF0); check("R9 set high keeps low", rb(8), 8'hFF);
    write_reg("R9 write", 8'h08, 8'h00); check("R9 zero no effect", rb(8), 8'hFF);
    read_one("R9 readback", 8'h08, 8'hFF);
  endtask

  task automatic t_flags();
    hw_set = 8'h81; tick(1);
    hw_set = 8'h00; tick(1);
    check("R10 hw sets", rb(9), 8'h81);
    write_reg("R10 write", 8'h09, 8'h01); check("R10 w1c", rb(9), 8'h80);
    write_reg("R10 write", 8'h09, 8'h00); check("R10 zero no effect", rb(9), 8'h80);
  endtask

  task automatic t_status();
    write_reg("R11 write", 8'h0B, 8'h55); check("R11 bus write ignored", rb(11), 8'h00);
    hw_stat = 8'h3C; hw_we = 1'b1; tick(1);
    hw_we = 1'b0; hw_stat = 8'hEE; tick(1);
    check("R11 hw load", rb(11), 8'h3C);
    read_one("R11 readback", 8'h0B, 8'h3C);
  endtask

  task automatic t_unimpl();
    logic [NREG*8-1:0] snap;
    snap = regs;
    write_reg("R12 write acked", 8'h1E, 8'h77);
    check("R12 no register changed", {7'd0, regs == snap}, 8'h01);
    read_one("R12 reads zero", 8'h1E, 8'h00);
  endtask

  task automatic t_nack_restart();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte({own, 1'b0}, a);
    put_byte(8'h0C, a);
    put_byte(8'h99, a);
    put_byte(8'h66, a);
    bus_stop();
    bus_start();
    put_byte({own, 1'b0}, a);
    put_byte(8'h0C, a);
    bus_start();
    put_byte({own, 1'b1}, a); check("R7 restart addr ack", {7'd0, a}, 8'h01);
    get_byte(v, 1'b0);        check("R7 read after restart", v, 8'h99);
    for (int i = 0; i < 3; i++) begin
      put_bit(1'b0);
      check("R7 released after nack", {7'd0, sda_oe}, 8'h00);
    end
    bus_start();
    put_byte({own, 1'b1}, a); check("R7 second restart ack", {7'd0, a}, 8'h01);
    get_byte(v, 1'b0);        check("R7 pointer kept", v, 8'h66);
    bus_stop();
    check("R13 released after stop", {7'd0, sda_oe}, 8'h00);
  endtask

  initial begin
    own = exp_addr(2'b00, 2'b00);
    tick(5);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_first_read();
    t_straps();
    t_write_burst();
    t_pointer_read();
    t_set_bits();
    t_flags();
    t_status();
    t_unimpl();
    t_nack_restart();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule